// File: doc/BRIEF.md
# Dual Addressable Latch with Decoder

This block holds two four-bit register banks, a and b, that are loaded one bit at a time at a chosen position. Both banks share one bit-select address, one active-low write enable and one active-low clear. Each bank has its own single-bit data input and four parallel outputs. The clear and enable levels together pick one of four modes: positional write, hold, one-of-four decode, and clear. A serial stream can therefore be scattered into a parallel word at random positions. With the data inputs tied high, the block also works as two active-high one-of-four decoders.

The model is synchronous. Storage updates on the rising clock edge from the inputs sampled in that cycle. The outputs are combinational from the present inputs and the stored bits. A bit therefore holds the data level of the last clock edge at which enable was low with that bit addressed. The address must stay stable while enable is low, or bits other than the intended one are written. The data inputs are plain levels: there is no stream handshake and no back-pressure.

A separate synchronous reset clears both banks. It does not change how the mode logic drives the outputs.

Top module: `dal_latch`

## Requirements
- R1: The two banks are independent in data. With the same address and mode, bank a uses only `din_a` and bank b uses only `din_b`, even when the two data levels differ.
- R2: In write mode (`clr_n`=1, `en_n`=0), the addressed output of each bank equals that bank's data input in the same cycle, before any clock edge.
- R3: In write mode, the rising clock edge stores the bank's data input into the addressed bit, and every unaddressed bit keeps its value. When enable stays low for several cycles, the level at the last edge is the one kept.
- R4: In hold mode (`clr_n`=1, `en_n`=1), all eight outputs show the stored bits. Changes on address and data have no effect on them.
- R5: In decode mode (`clr_n`=0, `en_n`=0), the addressed output of each bank equals its data input and the other three outputs are 0. With the data input at 1 the outputs are one-hot.
- R6: In clear mode (`clr_n`=0, `en_n`=1), all eight outputs are 0, whatever the address and data.
- R7: Address value n selects output bit n of each bank (`addr`[0] is the least significant bit; bit 0 is `q_a[0]`/`q_b[0]`).
- R8: Any clock edge with `clr_n`=0, in decode or clear mode, zeroes all storage. After returning to hold mode, every output reads 0 until it is written again.
- R9: A clock edge with `srst`=1 zeroes all storage. A following hold cycle then shows all outputs at 0.
- R10: One write cycle updates the same bit position in both banks at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; storage updates on the rising edge |
| srst | input | 1 | Synchronous reset, active high; clears both banks |
| addr | input | ADDR_W | Bit-select address shared by both banks |
| en_n | input | 1 | Write enable, active low |
| clr_n | input | 1 | Master clear, active low; selects decode or clear mode |
| din_a | input | 1 | Serial data input of bank a |
| din_b | input | 1 | Serial data input of bank b |
| q_a | output | 2**ADDR_W | Parallel outputs of bank a |
| q_b | output | 2**ADDR_W | Parallel outputs of bank b |

## Verification
The hardest case is decode mode: it clears storage silently while the outputs still show data. The effect only appears later, when the block returns to hold mode and must read all zeros. The stimulus first fills both banks with different patterns. It then walks decode mode over every address and data level, and then checks hold mode. It also switches modes while the data inputs are held steady, and runs a long pseudo-random phase. Throughout, all eight outputs are compared on every cycle with a behavioural model.

// File: rtl/dal_pkg.sv
package dal_pkg;
  localparam int NBANK = 2;

  typedef enum logic [1:0] {
    MODE_CLEAR  = 2'd0,
    MODE_DECODE = 2'd1,
    MODE_WRITE  = 2'd2,
    MODE_HOLD   = 2'd3
  } dal_mode_e;
endpackage

// File: rtl/dal_mode_decode.sv
module dal_mode_decode
  import dal_pkg::*;
(
  input  logic      clr_n,
  input  logic      en_n,
  output dal_mode_e mode
);
  always_comb begin
    unique case ({clr_n, en_n})
      2'b00:   mode = MODE_DECODE;
      2'b01:   mode = MODE_CLEAR;
      2'b10:   mode = MODE_WRITE;
      default: mode = MODE_HOLD;
    endcase
  end
endmodule

// File: rtl/dal_addr_decode.sv
module dal_addr_decode #(
  parameter int ADDR_W = 2,
  localparam int NBITS = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NBITS-1:0]  sel
);
  for (genvar i = 0; i < NBITS; i++) begin : g_sel
    assign sel[i] = (addr == ADDR_W'(i));
  end
endmodule

// File: rtl/dal_bank.sv
module dal_bank
  import dal_pkg::*;
#(
  parameter int ADDR_W = 2,
  localparam int NBITS = 1 << ADDR_W
) (
  input  logic             clk,
  input  logic             srst,
  input  dal_mode_e        mode,
  input  logic [NBITS-1:0] sel,
  input  logic             din,
  output logic [NBITS-1:0] q
);
  logic [NBITS-1:0] store_q;

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (srst) begin
        store_q[i] <= 1'b0;
      end else begin
        unique case (mode)
          MODE_CLEAR, MODE_DECODE: store_q[i] <= 1'b0;
          MODE_WRITE:              if (sel[i]) store_q[i] <= din;
          default:                 store_q[i] <= store_q[i];
        endcase
      end
    end

    always_comb begin
      unique case (mode)
        MODE_CLEAR:  q[i] = 1'b0;
        MODE_DECODE: q[i] = sel[i] & din;
        MODE_WRITE:  q[i] = sel[i] ? din : store_q[i];
        default:     q[i] = store_q[i];
      endcase
    end
  end
endmodule

// File: rtl/dal_latch.sv
module dal_latch
  import dal_pkg::*;
#(
  parameter int ADDR_W = 2,
  localparam int NBITS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              srst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              en_n,
  input  logic              clr_n,
  input  logic              din_a,
  input  logic              din_b,
  output logic [NBITS-1:0]  q_a,
  output logic [NBITS-1:0]  q_b
);
  dal_mode_e        mode;
  logic [NBITS-1:0] sel;
  logic [NBANK-1:0] din_bus;
  logic [NBITS-1:0] q_bus [NBANK];

  assign din_bus = {din_b, din_a};

  dal_mode_decode u_mode (
    .clr_n (clr_n),
    .en_n  (en_n),
    .mode  (mode)
  );

  dal_addr_decode #(.ADDR_W(ADDR_W)) u_sel (
    .addr (addr),
    .sel  (sel)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    dal_bank #(.ADDR_W(ADDR_W)) u_bank (
      .clk  (clk),
      .srst (srst),
      .mode (mode),
      .sel  (sel),
      .din  (din_bus[b]),
      .q    (q_bus[b])
    );
  end

  assign q_a = q_bus[0];
  assign q_b = q_bus[1];
endmodule

// File: rtl/dal_latch_chk.sv
module dal_latch_chk #(
  parameter int ADDR_W = 2,
  localparam int NBITS = 1 << ADDR_W
) (
  input logic              clk,
  input logic              srst,
  input logic [ADDR_W-1:0] addr,
  input logic              en_n,
  input logic              clr_n,
  input logic              din_a,
  input logic              din_b,
  input logic [NBITS-1:0]  q_a,
  input logic [NBITS-1:0]  q_b
);
  assert_write_shows_R2: assert property (@(posedge clk) disable iff (srst)
    (clr_n && !en_n) |-> (q_a[addr] == din_a && q_b[addr] == din_b));

  assert_capture_R3: assert property (@(posedge clk) disable iff (srst)
    ($past(clr_n && !en_n) && !$past(srst) && clr_n && en_n)
      |-> (q_a[$past(addr)] == $past(din_a) && q_b[$past(addr)] == $past(din_b)));

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (srst)
    (clr_n && en_n && $past(clr_n && en_n) && !$past(srst))
      |-> ($stable(q_a) && $stable(q_b)));

  assert_decode_onehot_R5: assert property (@(posedge clk) disable iff (srst)
    (!clr_n && !en_n) |-> ($countones(q_a) <= 1 && $countones(q_b) <= 1
                           && q_a[addr] == din_a && q_b[addr] == din_b));

  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (srst)
    (!clr_n && en_n) |-> (q_a == '0 && q_b == '0));

  assert_cleared_storage_R8: assert property (@(posedge clk) disable iff (srst)
    (clr_n && en_n && $past(!clr_n)) |-> (q_a == '0 && q_b == '0));
endmodule

bind dal_latch dal_latch_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk   (clk),
  .srst  (srst),
  .addr  (addr),
  .en_n  (en_n),
  .clr_n (clr_n),
  .din_a (din_a),
  .din_b (din_b),
  .q_a   (q_a),
  .q_b   (q_b)
);

// File: tb/dal_latch_tb.sv
module dal_latch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic       clk = 1'b0;
  logic       srst = 1'b1;
  logic [1:0] addr = '0;
  logic       en_n = 1'b1;
  logic       clr_n = 1'b1;
  logic       din_a = 1'b0;
  logic       din_b = 1'b0;
  logic [3:0] q_a;
  logic [3:0] q_b;

  int checks = 0;
  int fails = 0;
  bit model_a [4];
  bit model_b [4];

  always #(CLK_PERIOD/2) clk = ~clk;

  dal_latch #(.ADDR_W(2)) u_dut (
    .clk(clk), .srst(srst), .addr(addr), .en_n(en_n), .clr_n(clr_n),
    .din_a(din_a), .din_b(din_b), .q_a(q_a), .q_b(q_b)
  );

  function automatic logic [3:0] expect_q(input bit st [4], input int a,
                                          input bit e, input bit c, input bit d);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) begin
      if (!c && e)       r[i] = 1'b0;
      else if (!c && !e) r[i] = (i == a) ? d : 1'b0;
      else if (c && !e)  r[i] = (i == a) ? d : st[i];
      else               r[i] = st[i];
    end
    return r;
  endfunction

  function automatic string mode_tag(input bit e, input bit c);
    if (!c && e)  return "R6";
    if (!c && !e) return "R5";
    if (c && !e)  return "R2";
    return "R4";
  endfunction

  task automatic step(input int a, input bit e, input bit c, input bit da,
                      input bit db, input bit rs, input string tag);
    logic [3:0] ea, eb;
    @(negedge clk);
    addr = a[1:0]; en_n = e; clr_n = c; din_a = da; din_b = db; srst = rs;
    #1;
    ea = expect_q(model_a, a, e, c, da);
    eb = expect_q(model_b, a, e, c, db);
    checks++;
    if (q_a !== ea || q_b !== eb) begin
      fails++;
      $display("FAIL %s: q_a=%b q_b=%b expected q_a=%b q_b=%b (addr=%0d en_n=%0b clr_n=%0b)",
               (tag == "") ? mode_tag(e, c) : tag, q_a, q_b, ea, eb, a, e, c);
    end
    @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      if (rs || !c) begin
        model_a[i] = 1'b0; model_b[i] = 1'b0;
      end else if (!e && i == a) begin
        model_a[i] = da; model_b[i] = db;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    fails++;
    $display("FAIL watchdog: run did not complete, expected finish before timeout");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    for (int i = 0; i < 4; i++) begin model_a[i] = 1'b0; model_b[i] = 1'b0; end
    // R9 reset state in hold mode
    step(0, 1, 1, 1, 1, 0, "R9");
    // R7 / R10 / R1: write each position, banks get different data
    for (int a = 0; a < 4; a++) step(a, 0, 1, 1'b1, a[0], 0, "R7");
    step(2, 1, 1, 0, 0, 0, "R10");
    // R4: hold while address and data wander
    for (int a = 0; a < 4; a++) step(a, 1, 1, a[0], ~a[0], 0, "R4");
    // R3: rewrite one bit, neighbours keep value
    step(1, 0, 1, 0, 1, 0, "R3");
    step(1, 1, 1, 1, 0, 0, "R3");
    // R3: enable held low over changing data, last level kept
    step(3, 0, 1, 1, 1, 0, "R3");
    step(3, 0, 1, 0, 1, 0, "R3");
    step(3, 0, 1, 1, 0, 0, "R3");
    step(3, 1, 1, 0, 0, 0, "R3");
    // R1: differing data in write mode
    step(0, 0, 1, 0, 1, 0, "R1");
    step(0, 1, 1, 0, 0, 0, "R1");
    // R5 / R7: decode walk over every address and data level
    for (int a = 0; a < 4; a++)
      for (int d = 0; d < 2; d++) step(a, 0, 0, d[0], ~d[0], 0, "R5");
    step(2, 1, 1, 1, 1, 0, "R8");
    // refill, then clear mode with wandering inputs
    for (int a = 0; a < 4; a++) step(a, 0, 1, 1, 1, 0, "R2");
    for (int a = 0; a < 4; a++) step(a, 1, 0, 1, a[1], 0, "R6");
    step(0, 1, 1, 1, 1, 0, "R8");
    // mode changes with data held
    for (int m = 0; m < 4; m++) step(1, m[0], m[1], 1, 1, 0, "");
    for (int m = 3; m >= 0; m--) step(2, m[0], m[1], 1, 0, 0, "");
    // R9: synchronous reset clears filled storage
    for (int a = 0; a < 4; a++) step(a, 0, 1, 1, 1, 0, "R2");
    step(0, 1, 1, 0, 0, 1, "R9");
    step(0, 1, 1, 0, 0, 0, "R9");
    // pseudo-random phase
    for (int n = 0; n < 2000; n++) begin
      int r;
      r = $urandom;
      step(r & 3, r[2], (r[5:3] != 0), r[6], r[7], (r[15:8] == 0), "");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule